// File: doc/BRIEF.md
# Receiver phase-alignment bring-up sequencer

This block is a synchronous controller clocked by the receive user clock of a serial receiver. It runs the fixed, ordered procedure that lets the receiver bypass its elastic buffer and rely on a phase-alignment circuit instead. After a start request it pulses the receive datapath reset. It then waits for the optional clock-generator lock flag and for the recovered-clock (CDR) lock flag. Next it resets the alignment circuit for 20 cycles and raises phase-align enable. After a 32-cycle settle it pulses set-phase for 32 cycles and finally reports completion.

The delay-align override and delay-align disable controls stay high throughout, and an 8-bit override-setting bus carries a fixed code. Phase-align enable stays high once the procedure completes, because lowering it would lose the alignment. The only way to lower it is to rerun the procedure with a new start request. If a lock flag drops before completion, the controller abandons the attempt and starts again from the datapath reset. All pins are plain control and status levels; there is no data stream.

Top module: `phase_align_sequencer`

## Requirements
- R1: After reset, the following outputs are low: datapath reset, alignment reset, phase-align enable, set-phase and done. The sequencer then stays idle until a start request.
- R2: The override output and the disable output are high in every cycle, and the override-setting bus is always 8'b1000_0000 (only bit 7 set).
- R3: A start request sampled high at a clock edge makes the datapath reset output high from the next cycle, for exactly DP_RST_CYC cycles. A start request in any state, including during the datapath reset, restarts this count.
- R4: With USE_CLKGEN=1, after the datapath reset the sequencer waits for the clock-generator lock input, then for the CDR lock input. Losing clock-generator lock while waiting for CDR lock returns it to the datapath reset. With USE_CLKGEN=0 the clock-generator lock input has no effect on any output.
- R5: The alignment reset output rises the cycle after the lock conditions are seen and stays high for exactly ALIGN_RST_CYC (default 20) cycles.
- R6: Phase-align enable is low from reset until the alignment reset ends. It then goes high and stays high through completion, falling only on a restart or an abort.
- R7: Set-phase rises PRE_SET_CYC (default 32) cycles after phase-align enable rises and stays high for exactly SET_CYC (default 32) cycles.
- R8: Done rises in the cycle after set-phase falls and holds, whatever the lock inputs do, until a start request. A start request then lowers done, phase-align enable and set-phase, and raises the datapath reset.
- R9: If CDR lock is lost, or clock-generator lock is lost when it is used, during the alignment reset, the settle wait or set-phase, the next cycle shows the datapath reset high with phase-align enable and set-phase low.
- R10: At most one of datapath reset, alignment reset and set-phase is high in any cycle, and set-phase is never high without phase-align enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive user clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or restart request, sampled each edge |
| clkgen_lock_i | input | 1 | Lock flag of the clock generator feeding the user clocks |
| cdr_lock_i | input | 1 | Recovered-clock lock flag |
| dp_rst_o | output | 1 | Receive datapath reset |
| align_rst_o | output | 1 | Alignment-circuit reset |
| pa_en_o | output | 1 | Phase-align enable |
| set_phase_o | output | 1 | Set-phase command |
| dly_ovrd_o | output | 1 | Delay-align override, constant high |
| dly_dis_o | output | 1 | Delay-align disable, constant high |
| ovrd_setting_o | output | 8 | Override setting, constant 8'b1000_0000 |
| done_o | output | 1 | Bring-up complete |

## Verification
The bench builds two copies side by side and drives both from the same inputs. The first copy uses USE_CLKGEN=1 with DP_RST_CYC=3, which exposes the clock-generator wait, clock-generator loss while waiting for CDR lock, and a non-default datapath-reset length. The second copy uses USE_CLKGEN=0 with the default lengths. Toggling the clock-generator lock input on both copies therefore shows it taking effect on one and being ignored by the other. The default 20/32/32 cycle windows are kept on both copies so that the exact pulse lengths, aborts inside each window and restarts are compared against the model cycle by cycle.

// File: rtl/pas_pkg.sv
package pas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DPRST   = 3'd1,
    ST_WCLK    = 3'd2,
    ST_WCDR    = 3'd3,
    ST_ARST    = 3'd4,
    ST_PREWAIT = 3'd5,
    ST_SETPH   = 3'd6,
    ST_DONE    = 3'd7
  } pas_state_e;

  localparam logic [7:0] PAS_OVRD_SETTING = 8'b1000_0000;

  function automatic int pas_max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int pas_max4(input int a, input int b, input int c, input int d);
    return pas_max2(pas_max2(a, b), pas_max2(c, d));
  endfunction

endpackage

// File: rtl/pas_step_timer.sv
module pas_step_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (count_q != CNT_SAT) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/pas_ctrl_fsm.sv
module pas_ctrl_fsm
  import pas_pkg::*;
#(
  parameter bit USE_CLKGEN    = 1'b1,
  parameter int DP_RST_CYC    = 4,
  parameter int ALIGN_RST_CYC = 20,
  parameter int PRE_SET_CYC   = 32,
  parameter int SET_CYC       = 32,
  parameter int CNT_W         = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clkgen_lock_i,
  input  logic             cdr_lock_i,
  input  logic [CNT_W-1:0] count_i,
  output pas_state_e       state_o,
  output logic             clear_o
);

  localparam logic [CNT_W-1:0] DP_LAST  = CNT_W'(DP_RST_CYC - 1);
  localparam logic [CNT_W-1:0] AR_LAST  = CNT_W'(ALIGN_RST_CYC - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_SET_CYC - 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SET_CYC - 1);

  pas_state_e state_q, state_d;
  logic       clk_ok;
  logic       locks_ok;

  generate
    if (USE_CLKGEN) begin : g_clkgen_used
      assign clk_ok = clkgen_lock_i;
    end else begin : g_clkgen_skipped
      assign clk_ok = 1'b1;
    end
  endgenerate

  assign locks_ok = cdr_lock_i & clk_ok;

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = ST_DPRST;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_DPRST: begin
          if (count_i == DP_LAST) begin
            state_d = USE_CLKGEN ? ST_WCLK : ST_WCDR;
          end
        end
        ST_WCLK: begin
          if (clkgen_lock_i) state_d = ST_WCDR;
        end
        ST_WCDR: begin
          if (!clk_ok)         state_d = ST_DPRST;
          else if (cdr_lock_i) state_d = ST_ARST;
        end
        ST_ARST: begin
          if (!locks_ok)              state_d = ST_DPRST;
          else if (count_i == AR_LAST) state_d = ST_PREWAIT;
        end
        ST_PREWAIT: begin
          if (!locks_ok)               state_d = ST_DPRST;
          else if (count_i == PRE_LAST) state_d = ST_SETPH;
        end
        ST_SETPH: begin
          if (!locks_ok)               state_d = ST_DPRST;
          else if (count_i == SET_LAST) state_d = ST_DONE;
        end
        ST_DONE: state_d = ST_DONE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign clear_o = start_i | (state_d != state_q);
  assign state_o = state_q;

endmodule

// File: rtl/pas_out_decode.sv
module pas_out_decode
  import pas_pkg::*;
(
  input  pas_state_e  state_i,
  output logic        dp_rst_o,
  output logic        align_rst_o,
  output logic        pa_en_o,
  output logic        set_phase_o,
  output logic        done_o
);

  always_comb begin
    dp_rst_o    = 1'b0;
    align_rst_o = 1'b0;
    pa_en_o     = 1'b0;
    set_phase_o = 1'b0;
    done_o      = 1'b0;
    unique case (state_i)
      ST_DPRST:   dp_rst_o = 1'b1;
      ST_ARST:    align_rst_o = 1'b1;
      ST_PREWAIT: pa_en_o = 1'b1;
      ST_SETPH: begin
        pa_en_o     = 1'b1;
        set_phase_o = 1'b1;
      end
      ST_DONE: begin
        pa_en_o = 1'b1;
        done_o  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/phase_align_sequencer.sv
module phase_align_sequencer
  import pas_pkg::*;
#(
  parameter bit USE_CLKGEN    = 1'b1,
  parameter int DP_RST_CYC    = 4,
  parameter int ALIGN_RST_CYC = 20,
  parameter int PRE_SET_CYC   = 32,
  parameter int SET_CYC       = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       clkgen_lock_i,
  input  logic       cdr_lock_i,
  output logic       dp_rst_o,
  output logic       align_rst_o,
  output logic       pa_en_o,
  output logic       set_phase_o,
  output logic       dly_ovrd_o,
  output logic       dly_dis_o,
  output logic [7:0] ovrd_setting_o,
  output logic       done_o
);

  localparam int MAX_CYC = pas_max4(DP_RST_CYC, ALIGN_RST_CYC, PRE_SET_CYC, SET_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  pas_state_e       state;
  logic             timer_clear;
  logic [CNT_W-1:0] step_count;

  pas_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (timer_clear),
    .count_o (step_count)
  );

  pas_ctrl_fsm #(
    .USE_CLKGEN    (USE_CLKGEN),
    .DP_RST_CYC    (DP_RST_CYC),
    .ALIGN_RST_CYC (ALIGN_RST_CYC),
    .PRE_SET_CYC   (PRE_SET_CYC),
    .SET_CYC       (SET_CYC),
    .CNT_W         (CNT_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .clkgen_lock_i (clkgen_lock_i),
    .cdr_lock_i    (cdr_lock_i),
    .count_i       (step_count),
    .state_o       (state),
    .clear_o       (timer_clear)
  );

  pas_out_decode u_dec (
    .state_i     (state),
    .dp_rst_o    (dp_rst_o),
    .align_rst_o (align_rst_o),
    .pa_en_o     (pa_en_o),
    .set_phase_o (set_phase_o),
    .done_o      (done_o)
  );

  assign dly_ovrd_o     = 1'b1;
  assign dly_dis_o      = 1'b1;
  assign ovrd_setting_o = PAS_OVRD_SETTING;

endmodule

// File: rtl/pas_checker.sv
module pas_checker #(
  parameter bit USE_CLKGEN    = 1'b1,
  parameter int ALIGN_RST_CYC = 20,
  parameter int PRE_SET_CYC   = 32,
  parameter int SET_CYC       = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       clkgen_lock_i,
  input logic       cdr_lock_i,
  input logic       dp_rst_o,
  input logic       align_rst_o,
  input logic       pa_en_o,
  input logic       set_phase_o,
  input logic       dly_ovrd_o,
  input logic       dly_dis_o,
  input logic [7:0] ovrd_setting_o,
  input logic       done_o
);

  logic [15:0] ar_run, pw_run, sp_run;
  logic        clk_ok;

  assign clk_ok = (USE_CLKGEN == 1'b0) || clkgen_lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_run <= '0;
      pw_run <= '0;
      sp_run <= '0;
    end else begin
      ar_run <= align_rst_o ? ar_run + 1'b1 : '0;
      pw_run <= (pa_en_o && !set_phase_o && !done_o) ? pw_run + 1'b1 : '0;
      sp_run <= set_phase_o ? sp_run + 1'b1 : '0;
    end
  end

  p_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dly_ovrd_o && dly_dis_o && (ovrd_setting_o == 8'b1000_0000));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> dp_rst_o && !pa_en_o && !done_o);

  p_clkgen_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_CLKGEN && !clkgen_lock_i && !align_rst_o) |=> !align_rst_o);

  p_arst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(align_rst_o) && pa_en_o) |-> (ar_run == 16'(ALIGN_RST_CYC)));

  p_paen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_en_o && !start_i && (done_o || (cdr_lock_i && clk_ok))) |=> pa_en_o);

  p_setph_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(set_phase_o) |-> (pw_run == 16'(PRE_SET_CYC)));

  p_setph_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(set_phase_o) && done_o) |-> (sp_run == 16'(SET_CYC)));

  p_done_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(set_phase_o) && !dp_rst_o) |-> done_o);

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((align_rst_o || (pa_en_o && !done_o)) && !(cdr_lock_i && clk_ok))
      |=> dp_rst_o && !pa_en_o && !set_phase_o);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dp_rst_o, align_rst_o, set_phase_o}) && (!set_phase_o || pa_en_o));

endmodule

bind phase_align_sequencer pas_checker #(
  .USE_CLKGEN    (USE_CLKGEN),
  .ALIGN_RST_CYC (ALIGN_RST_CYC),
  .PRE_SET_CYC   (PRE_SET_CYC),
  .SET_CYC       (SET_CYC)
) u_pas_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .clkgen_lock_i  (clkgen_lock_i),
  .cdr_lock_i     (cdr_lock_i),
  .dp_rst_o       (dp_rst_o),
  .align_rst_o    (align_rst_o),
  .pa_en_o        (pa_en_o),
  .set_phase_o    (set_phase_o),
  .dly_ovrd_o     (dly_ovrd_o),
  .dly_dis_o      (dly_dis_o),
  .ovrd_setting_o (ovrd_setting_o),
  .done_o         (done_o)
);

// File: tb/phase_align_sequencer_test.sv
module pas_ref_model #(
  parameter bit USE_CLKGEN    = 1'b1,
  parameter int DP_RST_CYC    = 4,
  parameter int ALIGN_RST_CYC = 20,
  parameter int PRE_SET_CYC   = 32,
  parameter int SET_CYC       = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cg_lock,
  input  logic cdr_lock,
  output logic e_dp,
  output logic e_ar,
  output logic e_pa,
  output logic e_sp,
  output logic e_done
);
  // phase: 0 idle, 1 datapath reset, 2 wait clkgen, 3 wait cdr,
  //        4 align reset, 5 settle, 6 set-phase, 7 complete
  int phase = 0;
  int left  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0;
      left  = 0;
    end else if (start) begin
      phase = 1;
      left  = DP_RST_CYC;
    end else begin
      case (phase)
        1: begin
          left = left - 1;
          if (left == 0) phase = USE_CLKGEN ? 2 : 3;
        end
        2: if (cg_lock) phase = 3;
        3: begin
          if (USE_CLKGEN && !cg_lock) begin
            phase = 1; left = DP_RST_CYC;
          end else if (cdr_lock) begin
            phase = 4; left = ALIGN_RST_CYC;
          end
        end
        4, 5, 6: begin
          if (!cdr_lock || (USE_CLKGEN && !cg_lock)) begin
            phase = 1; left = DP_RST_CYC;
          end else begin
            left = left - 1;
            if (left == 0) begin
              phase = phase + 1;
              if (phase == 5) left = PRE_SET_CYC;
              else if (phase == 6) left = SET_CYC;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign e_dp   = (phase == 1);
  assign e_ar   = (phase == 4);
  assign e_pa   = (phase >= 5);
  assign e_sp   = (phase == 6);
  assign e_done = (phase == 7);
endmodule

module phase_align_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cg_lock = 1'b0;
  logic cdr_lock = 1'b0;

  always #10 clk = ~clk;

  logic       a_dp, a_ar, a_pa, a_sp, a_ov, a_di, a_done;
  logic [7:0] a_set;
  logic       b_dp, b_ar, b_pa, b_sp, b_ov, b_di, b_done;
  logic [7:0] b_set;
  logic       ea_dp, ea_ar, ea_pa, ea_sp, ea_done;
  logic       eb_dp, eb_ar, eb_pa, eb_sp, eb_done;

  phase_align_sequencer #(.USE_CLKGEN(1'b1), .DP_RST_CYC(3)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .clkgen_lock_i(cg_lock),
    .cdr_lock_i(cdr_lock), .dp_rst_o(a_dp), .align_rst_o(a_ar), .pa_en_o(a_pa),
    .set_phase_o(a_sp), .dly_ovrd_o(a_ov), .dly_dis_o(a_di),
    .ovrd_setting_o(a_set), .done_o(a_done));

  phase_align_sequencer #(.USE_CLKGEN(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .start_i(start), .clkgen_lock_i(cg_lock),
    .cdr_lock_i(cdr_lock), .dp_rst_o(b_dp), .align_rst_o(b_ar), .pa_en_o(b_pa),
    .set_phase_o(b_sp), .dly_ovrd_o(b_ov), .dly_dis_o(b_di),
    .ovrd_setting_o(b_set), .done_o(b_done));

  pas_ref_model #(.USE_CLKGEN(1'b1), .DP_RST_CYC(3)) ref_a (
    .clk(clk), .rst_n(rst_n), .start(start), .cg_lock(cg_lock), .cdr_lock(cdr_lock),
    .e_dp(ea_dp), .e_ar(ea_ar), .e_pa(ea_pa), .e_sp(ea_sp), .e_done(ea_done));

  pas_ref_model #(.USE_CLKGEN(1'b0)) ref_b (
    .clk(clk), .rst_n(rst_n), .start(start), .cg_lock(cg_lock), .cdr_lock(cdr_lock),
    .e_dp(eb_dp), .e_ar(eb_ar), .e_pa(eb_pa), .e_sp(eb_sp), .e_done(eb_done));

  int    compared = 0;
  int    mismatched = 0;
  int    cycles = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s (%s) %s at %0t: actual %0h expected %0h", req, tag, what,
               $time, act, exp);
    end
  endtask

  // every-cycle comparison with the reference model, away from the edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3", "uut dp_rst", {7'd0, a_dp}, {7'd0, ea_dp});
      chk("R5", "uut align_rst", {7'd0, a_ar}, {7'd0, ea_ar});
      chk("R6", "uut pa_en", {7'd0, a_pa}, {7'd0, ea_pa});
      chk("R7", "uut set_phase", {7'd0, a_sp}, {7'd0, ea_sp});
      chk("R8", "uut done", {7'd0, a_done}, {7'd0, ea_done});
      chk("R2", "uut ovrd/dis/setting", {a_ov, a_di, a_set[5:0]}, 8'b1100_0000);
      chk("R2", "uut setting bit 7..6", {6'd0, a_set[7:6]}, 8'd2);
      chk("R4", "uut_b dp_rst", {7'd0, b_dp}, {7'd0, eb_dp});
      chk("R4", "uut_b align_rst", {7'd0, b_ar}, {7'd0, eb_ar});
      chk("R6", "uut_b pa_en", {7'd0, b_pa}, {7'd0, eb_pa});
      chk("R7", "uut_b set_phase", {7'd0, b_sp}, {7'd0, eb_sp});
      chk("R8", "uut_b done", {7'd0, b_done}, {7'd0, eb_done});
      chk("R2", "uut_b setting", b_set & {8{b_ov & b_di}}, 8'h80);
      chk("R10", "uut exclusivity",
          {7'd0, ((a_dp + a_ar + a_sp) <= 1) && (!a_sp || a_pa)}, 8'd1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog (%s): actual timeout expected completion", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    step(1);
    start = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1: idle state after reset
    chk("R1", "reset outputs", {3'd0, a_dp, a_ar, a_pa, a_sp, a_done}, 8'd0);
    chk("R1", "reset outputs b", {3'd0, b_dp, b_ar, b_pa, b_sp, b_done}, 8'd0);

    // R4: clkgen wait on uut, ignored on uut_b
    tag = "R4";
    pulse_start();
    step(12);
    cdr_lock = 1'b1;
    step(6);
    cg_lock = 1'b1;
    step(110);
    chk("R8", "both done", {6'd0, a_done, b_done}, 8'd3);
    // R8: done holds when locks drop
    cdr_lock = 1'b0;
    cg_lock  = 1'b0;
    step(5);
    chk("R8", "done held", {6'd0, a_done, b_done}, 8'd3);
    cdr_lock = 1'b1;
    cg_lock  = 1'b1;

    // R3: restart during datapath reset and mid alignment reset
    tag = "R3";
    pulse_start();
    step(1);
    pulse_start();
    step(10);
    pulse_start();
    step(100);

    // R9: CDR loss in settle window, then clkgen loss in alignment reset
    tag = "R9";
    pulse_start();
    step(40);
    cdr_lock = 1'b0;
    step(3);
    cdr_lock = 1'b1;
    step(15);
    cg_lock = 1'b0;
    step(5);
    cg_lock = 1'b1;
    step(60);
    cdr_lock = 1'b0;
    step(2);
    cdr_lock = 1'b1;
    step(110);

    // R4: clkgen loss while waiting for CDR lock
    tag = "R4";
    cdr_lock = 1'b0;
    pulse_start();
    step(6);
    cg_lock = 1'b0;
    step(3);
    cg_lock = 1'b1;
    step(4);
    cdr_lock = 1'b1;
    step(100);

    // R8: restart from complete
    tag = "R8";
    pulse_start();
    step(1);
    chk("R8", "restart from done", {3'd0, a_dp, a_pa, a_sp, a_done, 1'b0}, 8'b0001_0000);
    step(5);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule